// File: doc/BRIEF.md
# Interpolating Reciprocal Counter Core

This core is the counting heart of a frequency and time-interval meter. It runs on the 10 MHz reference time base. It watches two asynchronous channel trigger inputs, A and B, each brought into the clock domain by its own synchroniser. Once the host arms it, the first rising trigger on channel A opens a measurement gate, and the next rising trigger on A closes it. Both gate edges fall on time base edges. While the gate is open the core counts time base cycles and the rising edges of the channel the host selected.

The gate is aligned to the clock, so each trigger lands some fraction of a period before the edge that acts on it. To recover that fraction the core drives two interpolator pulses, start and stop. Each pulse begins at the raw channel A rising edge and ends at the time base edge where the gate opens or closes. An external analog stretcher lengthens each pulse 200-fold and returns it. The core measures each stretched pulse by counting time base cycles while it is high.

A host reaches the core through a small register bus with four addresses. Writes take effect on the next clock edge and reads are combinational. A control bit chooses whether the two count addresses return the gate counts or the interpolator counts.

Top module: `irc_core`

## Requirements
- R1: After reset, every bus address reads zero and both interpolator pulse outputs are low.
- R2: The control word sits at address 3. Its fields are: bit 0 arm (always reads 0), bit 1 event source (0 = channel A, 1 = channel B), bit 2 count view, and bits 6:4 timeout select. All other bits read zero.
- R3: Writes to addresses 0, 1 and 2 change no register. Later reads return the same values as before the write.
- R4: While the gate is open, the time count (address 1 with count view 0) rises by one on every time base edge, including the edge that closes the gate. It then holds until the next arm.
- R5: A channel A rising edge reaches the core after two synchroniser stages and one edge-detect stage. When the core is waiting, the gate opens on the third clock edge after that rising edge. interp_start_o is high from the rising edge until that clock edge, and is low in every other state.
- R6: Once the gate is open and channel A has been seen low, the next channel A rising edge closes the gate on the third clock edge after it. interp_stop_o is high from that rising edge until the closing edge.
- R7: The event count (address 0 with count view 0) counts the rising edges of the selected source that are detected on edges where the gate is open. With source A this includes the closing edge, so a single gate counts 1.
- R8: With count view 1, address 0 returns the start interpolator count and address 1 returns the stop interpolator count. Each count is the number of cycles for which its synchronised stretched return is high after arming. A count is complete and frozen once its return falls.
- R9: The status word at address 2 has these bits: bit 0 done, bit 1 timeout, bit 2 gate open, bit 3 waiting for start, bit 4 start interpolation complete, bit 5 stop interpolation complete. Done means the gate has closed, the start count is complete, and either the stop count is complete or a timeout occurred.
- R10: A control write with the arm bit set clears the event count, the time count, both interpolator counts and all status flags, and puts the core in the waiting state.
- R11: The timeout limit is 16 shifted left by the timeout select value. If the time count reaches the limit before a stop trigger, the gate closes with the time count equal to the limit and the timeout bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference time base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cs | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_cs |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ch_a_i | input | 1 | Channel A trigger, asynchronous |
| ch_b_i | input | 1 | Channel B trigger, asynchronous |
| xp_start_i | input | 1 | Stretched start interpolator return, asynchronous |
| xp_stop_i | input | 1 | Stretched stop interpolator return, asynchronous |
| interp_start_o | output | 1 | Start interpolator pulse |
| interp_stop_o | output | 1 | Stop interpolator pulse |

## Verification
The bench builds the core with its default widths of 16 bits. Timeout select values 7 and 0 give limits of 2048 and 16 cycles, so a short gate with no stop trigger shows the forced close, and longer gates end on the stop trigger. The bench drives triggers at two different sub-period offsets. This gives start and stop interpolator pulses of different widths, so their stretched counts (550 and 480 cycles) can be told apart. The bench also steps channel B during gates with each event source selected, which shows that the source choice is honoured.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int TSEL_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GATE = 2'd2,
    ST_DONE = 2'd3
  } irc_state_e;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_TIM  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic              view;
    logic              src;
  } irc_ctrl_t;
endpackage

// File: rtl/irc_sync.sv
module irc_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] m1_q, m2_q, d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q <= '0;
      m2_q <= '0;
      d_q  <= '0;
    end else begin
      m1_q <= async_i;
      m2_q <= m1_q;
      d_q  <= m2_q;
    end
  end

  assign level_o = m2_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise_o[i] = m2_q[i] & ~d_q[i];
  end
endmodule

// File: rtl/irc_interp_cnt.sv
module irc_interp_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cmp_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d, cmp_q, cmp_d;
  logic             upd;

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    cmp_d  = cmp_q;
    if (clr_i) begin
      cnt_d  = '0;
      seen_d = 1'b0;
      cmp_d  = 1'b0;
    end else if (pulse_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      seen_d = 1'b1;
    end else if (seen_q) begin
      cmp_d = 1'b1;
    end
  end

  assign upd = clr_i | (en_i & ~cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      cmp_q  <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      cmp_q  <= cmp_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/irc_gate_fsm.sv
module irc_gate_fsm
  import irc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TO_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              a_raw_i,
  input  logic              a_level_i,
  input  logic              a_rise_i,
  input  logic              b_rise_i,
  input  logic              src_i,
  input  logic [TSEL_W-1:0] tsel_i,
  output irc_state_e        state_o,
  output logic [CNT_W-1:0]  ev_o,
  output logic [CNT_W-1:0]  tm_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic              timeout_o,
  output logic              start_pulse_o,
  output logic              stop_pulse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  irc_state_e       st_q, st_d;
  logic [CNT_W-1:0] ev_q, ev_d, tm_q, tm_d;
  logic             to_q, to_d, rdy_q, rdy_d;
  logic             ev_hit, upd;

  assign lim_o  = CNT_W'(TO_BASE) << tsel_i;
  assign ev_hit = src_i ? b_rise_i : a_rise_i;

  always_comb begin
    st_d  = st_q;
    ev_d  = ev_q;
    tm_d  = tm_q;
    to_d  = to_q;
    rdy_d = rdy_q;
    if (arm_i) begin
      st_d  = ST_WAIT;
      ev_d  = '0;
      tm_d  = '0;
      to_d  = 1'b0;
      rdy_d = 1'b0;
    end else begin
      case (st_q)
        ST_WAIT: if (a_rise_i) st_d = ST_GATE;
        ST_GATE: begin
          if (tm_q != CNT_MAX) tm_d = tm_q + 1'b1;
          if (ev_hit && ev_q != CNT_MAX) ev_d = ev_q + 1'b1;
          if (!a_level_i) rdy_d = 1'b1;
          if (a_rise_i) begin
            st_d = ST_DONE;
          end else if (tm_d == lim_o) begin
            st_d = ST_DONE;
            to_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign upd = arm_i | (st_q == ST_WAIT) | (st_q == ST_GATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ev_q  <= '0;
      tm_q  <= '0;
      to_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else if (upd) begin
      st_q  <= st_d;
      ev_q  <= ev_d;
      tm_q  <= tm_d;
      to_q  <= to_d;
      rdy_q <= rdy_d;
    end
  end

  assign state_o       = st_q;
  assign ev_o          = ev_q;
  assign tm_o          = tm_q;
  assign timeout_o     = to_q;
  assign start_pulse_o = (st_q == ST_WAIT) & a_raw_i;
  assign stop_pulse_o  = (st_q == ST_GATE) & rdy_q & a_raw_i;
endmodule

// File: rtl/irc_core.sv
module irc_core
  import irc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int TO_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ch_a_i,
  input  logic              ch_b_i,
  input  logic              xp_start_i,
  input  logic              xp_stop_i,
  output logic              interp_start_o,
  output logic              interp_stop_o
);
  localparam int N_SYNC = 4;
  localparam int CTRL_W = TSEL_W + 4;

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic [N_SYNC-1:0] sy_lvl, sy_rise;
  irc_ctrl_t         ctrl_q, ctrl_d;
  logic              wr_ctrl, arm;
  irc_state_e        st;
  logic [CNT_W-1:0]  ev_cnt, tm_cnt, lim;
  logic              timeout;
  logic [CNT_W-1:0]  icnt [2];
  logic [1:0]        icmp;
  logic              done;
  logic [5:0]        status;
  logic              unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  irc_sync #(.N(N_SYNC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i ({xp_stop_i, xp_start_i, ch_b_i, ch_a_i}),
    .level_o (sy_lvl),
    .rise_o  (sy_rise)
  );

  assign wr_ctrl = bus_cs & bus_we & (bus_addr == ADDR_CTRL);
  assign arm     = wr_ctrl & bus_wdata[0];

  always_comb begin
    ctrl_d.src  = bus_wdata[1];
    ctrl_d.view = bus_wdata[2];
    ctrl_d.tsel = bus_wdata[4 +: TSEL_W];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  irc_gate_fsm #(.CNT_W(CNT_W), .TO_BASE(TO_BASE)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .arm_i         (arm),
    .a_raw_i       (ch_a_i),
    .a_level_i     (sy_lvl[0]),
    .a_rise_i      (sy_rise[0]),
    .b_rise_i      (sy_rise[1]),
    .src_i         (ctrl_q.src),
    .tsel_i        (ctrl_q.tsel),
    .state_o       (st),
    .ev_o          (ev_cnt),
    .tm_o          (tm_cnt),
    .lim_o         (lim),
    .timeout_o     (timeout),
    .start_pulse_o (interp_start_o),
    .stop_pulse_o  (interp_stop_o)
  );

  for (genvar k = 0; k < 2; k++) begin : g_interp
    irc_interp_cnt #(.CNT_W(CNT_W)) u_ic (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clr_i   (arm),
      .en_i    (st != ST_IDLE),
      .pulse_i (sy_lvl[2+k]),
      .cnt_o   (icnt[k]),
      .cmp_o   (icmp[k])
    );
  end

  assign done   = (st == ST_DONE) & icmp[0] & (icmp[1] | timeout);
  assign status = {icmp[1], icmp[0], st == ST_WAIT, st == ST_GATE, timeout, done};

  always_comb begin
    case (bus_addr)
      ADDR_CNT:  bus_rdata = ctrl_q.view ? DATA_W'(icnt[0]) : DATA_W'(ev_cnt);
      ADDR_TIM:  bus_rdata = ctrl_q.view ? DATA_W'(icnt[1]) : DATA_W'(tm_cnt);
      ADDR_STAT: bus_rdata = DATA_W'(status);
      default:   bus_rdata = DATA_W'({ctrl_q.tsel, 1'b0, ctrl_q.view, ctrl_q.src, 1'b0});
    endcase
  end

  assign unused_bits = ^{bus_wdata[DATA_W-1:CTRL_W], bus_wdata[3], sy_lvl[1], sy_rise[3:2]};
endmodule

// File: rtl/irc_core_chk.sv
module irc_core_chk
  import irc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input irc_state_e       state,
  input logic             arm,
  input logic             a_rise,
  input logic             interp_start,
  input logic [CNT_W-1:0] tm_cnt,
  input logic [CNT_W-1:0] ev_cnt,
  input logic [CNT_W-1:0] lim,
  input logic             done
);
  assert_gate_opens_on_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GATE && $past(state) == ST_WAIT) |-> $past(a_rise));

  assert_start_pulse_only_waiting_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_WAIT) |-> !interp_start);

  assert_time_within_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GATE) |-> (tm_cnt < lim));

  assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (ev_cnt == '0 && tm_cnt == '0 && state == ST_WAIT));

  assert_time_frozen_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !arm) |=> $stable(tm_cnt));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);
endmodule

bind irc_core irc_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .state        (st),
  .arm          (arm),
  .a_rise       (sy_rise[0]),
  .interp_start (interp_start_o),
  .tm_cnt       (tm_cnt),
  .ev_cnt       (ev_cnt),
  .lim          (lim),
  .done         (done)
);

// File: tb/tb_irc_core.sv
module tb_irc_core;
  localparam int P       = 100;
  localparam int STRETCH = 200;

  logic        clk, rst_n, bus_cs, bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        ch_a, ch_b, xp_s, xp_p, ip_s, ip_p;

  int n_chk = 0, n_bad = 0;
  int w_start = 0, w_stop = 0, n_start = 0, n_stop = 0;

  irc_core dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_a_i(ch_a), .ch_b_i(ch_b), .xp_start_i(xp_s), .xp_stop_i(xp_p),
    .interp_start_o(ip_s), .interp_stop_o(ip_p)
  );

  initial clk = 1'b0;
  always #(P/2) clk = ~clk;

  // behavioural reference model
  int m_rs, m_st, m_ev, m_tm, m_to, m_rdy, m_src, m_view, m_tsel;
  int m_sc, m_sseen, m_scmp, m_pc, m_pseen, m_pcmp;
  int a1, a2, a3, b1, b2, b3, s1, s2, p1, p2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_st = 0; m_ev = 0; m_tm = 0; m_to = 0; m_rdy = 0;
      m_src = 0; m_view = 0; m_tsel = 0;
      m_sc = 0; m_sseen = 0; m_scmp = 0; m_pc = 0; m_pseen = 0; m_pcmp = 0;
      a1 = 0; a2 = 0; a3 = 0; b1 = 0; b2 = 0; b3 = 0; s1 = 0; s2 = 0; p1 = 0; p2 = 0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      int ra, rb, old;
      ra  = (a2 == 1 && a3 == 0);
      rb  = (b2 == 1 && b3 == 0);
      old = m_st;
      if (bus_cs && bus_we && bus_addr == 2'd3) begin
        m_src = bus_wdata[1]; m_view = bus_wdata[2]; m_tsel = int'(bus_wdata[6:4]);
      end
      if (bus_cs && bus_we && bus_addr == 2'd3 && bus_wdata[0]) begin
        m_st = 1; m_ev = 0; m_tm = 0; m_to = 0; m_rdy = 0;
        m_sc = 0; m_sseen = 0; m_scmp = 0; m_pc = 0; m_pseen = 0; m_pcmp = 0;
      end else begin
        if (old != 0) begin
          if (!m_scmp) begin
            if (s2) begin if (m_sc < 65535) m_sc++; m_sseen = 1; end
            else if (m_sseen) m_scmp = 1;
          end
          if (!m_pcmp) begin
            if (p2) begin if (m_pc < 65535) m_pc++; m_pseen = 1; end
            else if (m_pseen) m_pcmp = 1;
          end
        end
        if (old == 1 && ra) m_st = 2;
        if (old == 2) begin
          if (m_tm < 65535) m_tm++;
          if ((m_src ? rb : ra) && m_ev < 65535) m_ev++;
          if (a2 == 0) m_rdy = 1;
          if (ra) m_st = 3;
          else if (m_tm == (16 << m_tsel)) begin m_st = 3; m_to = 1; end
        end
      end
      a3 = a2; a2 = a1; a1 = int'(ch_a);
      b3 = b2; b2 = b1; b1 = int'(ch_b);
      s2 = s1; s1 = int'(xp_s);
      p2 = p1; p1 = int'(xp_p);
    end
  end

  function automatic int m_rdata(input logic [1:0] ad);
    int dn;
    dn = (m_st == 3 && m_scmp && (m_pcmp || m_to)) ? 1 : 0;
    case (ad)
      2'd0: return m_view ? m_sc : m_ev;
      2'd1: return m_view ? m_pc : m_tm;
      2'd2: return (m_pcmp << 5) | (m_scmp << 4) | ((m_st == 1) << 3) | ((m_st == 2) << 2) | (m_to << 1) | dn;
      default: return (m_tsel << 4) | (m_view << 2) | (m_src << 1);
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      string tg;
      case (bus_addr)
        2'd0: tg = m_view ? "R8 start count" : "R7 events";
        2'd1: tg = m_view ? "R8 stop count" : "R4 time";
        2'd2: tg = "R9 status";
        default: tg = "R2 control";
      endcase
      check(tg, int'(bus_rdata), m_rdata(bus_addr));
      check("R5 start pulse", int'(ip_s), int'(m_st == 1 && ch_a));
      check("R6 stop pulse", int'(ip_p), int'(m_st == 2 && m_rdy != 0 && ch_a));
    end
  end

  // analog stretcher stand-ins
  initial begin
    xp_s = 1'b0;
    forever begin
      int t0;
      @(posedge ip_s); t0 = int'($time);
      @(negedge ip_s); w_start = int'($time) - t0;
      n_start = (w_start * STRETCH + P/2) / P;
      #(P/4) xp_s = 1'b1;
      repeat (n_start) @(posedge clk);
      #(P/4) xp_s = 1'b0;
    end
  end

  initial begin
    xp_p = 1'b0;
    forever begin
      int t0;
      @(posedge ip_p); t0 = int'($time);
      @(negedge ip_p); w_stop = int'($time) - t0;
      n_stop = (w_stop * STRETCH + P/2) / P;
      #(P/4) xp_p = 1'b1;
      repeat (n_stop) @(posedge clk);
      #(P/4) xp_p = 1'b0;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #(P/4);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #(P/4);
    bus_cs = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(posedge clk); #(P/4);
    bus_addr = a;
    @(negedge clk); #1;
    v = int'(bus_rdata);
  endtask

  task automatic a_start();
    @(posedge clk); #(P/4) ch_a = 1'b1;
    repeat (3) @(posedge clk);
    #(P/4) ch_a = 1'b0;
  endtask

  task automatic gate_run(input int d);
    a_start();
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #(P/4) ch_b = 1'b1;
      @(posedge clk); #(P/4) ch_b = 1'b0;
    end
    repeat (d - 13) @(posedge clk);
    #(P*6/10) ch_a = 1'b1;
    repeat (3) @(posedge clk);
    #(P/4) ch_a = 1'b0;
  endtask

  task automatic wait_done();
    int v;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd2, v);
      if (v[0]) break;
    end
  endtask

  initial begin
    int v;
    rst_n = 1'b0; bus_cs = 1'b0; bus_we = 1'b0; bus_addr = 2'd2; bus_wdata = '0;
    ch_a = 1'b0; ch_b = 1'b0;
    repeat (4) @(posedge clk);
    #(P/4) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reset read", v, 0);
    end
    check("R1 start pulse low", int'(ip_s), 0);
    check("R1 stop pulse low", int'(ip_p), 0);

    wr(2'd0, 16'hFFFF); wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R3 ignored write", v, 0);
    end

    // gate ended by a stop trigger, events from channel B
    wr(2'd3, 16'h0073);
    rd(2'd3, v); check("R2 control readback", v, 'h72);
    rd(2'd2, v); check("R9 waiting status", v, 'h08);
    gate_run(40);
    wait_done();
    rd(2'd0, v); check("R7 channel B events", v, 5);
    rd(2'd1, v); check("R4 gate time", v, 40);
    rd(2'd2, v); check("R9 done status", v, 'h31);
    check("R5 start pulse width", w_start, 275);
    check("R6 stop pulse width", w_stop, 240);
    wr(2'd1, 16'h0000);
    rd(2'd1, v); check("R3 time kept after write", v, 40);
    wr(2'd3, 16'h0076);
    rd(2'd0, v); check("R8 start interp count", v, n_start);
    check("R8 start count value", v, 550);
    rd(2'd1, v); check("R8 stop interp count", v, n_stop);
    check("R8 stop count value", v, 480);

    // re-arm, events from channel A
    wr(2'd3, 16'h0071);
    rd(2'd0, v); check("R10 events cleared", v, 0);
    rd(2'd1, v); check("R10 time cleared", v, 0);
    rd(2'd2, v); check("R10 status cleared", v, 'h08);
    gate_run(20);
    wait_done();
    rd(2'd0, v); check("R7 channel A events", v, 1);
    rd(2'd1, v); check("R4 gate time short", v, 20);

    // no stop trigger: forced close
    wr(2'd3, 16'h0001);
    a_start();
    wait_done();
    rd(2'd1, v); check("R11 time at limit", v, 16);
    rd(2'd2, v); check("R11 timeout status", v, 'h13);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule